// File: doc/BRIEF.md
# Store-Load Overlap Detector

This block tracks the stores committed into the current dispatch group and tells the group-forming logic whether a candidate load touches memory that one of those stores has written. Each recorded store keeps a base identifier, a signed byte offset from that base and an access size in bytes. A load that presents the same base and an overlapping byte range raises a hit. The group checker then knows that no-ops must be inserted before the load so that it falls into a later group.

Only a small, fixed number of stores is remembered per group. Stores beyond that number are dropped. A group-end pulse empties the record set. Base identifiers come from an earlier stage and are compared only for equality. The hit output is a purely combinational function of the load inputs and of the stored records.

Top module: `store_load_overlap`

## Requirements
- R1: After reset no store is recorded, and hit_o stays 0 for any load.
- R2: A load whose base equals a recorded store's base and whose offset equals that store's offset hits, even when either size is 0.
- R3: For equal bases, when the store offset is below the load offset, the load hits if and only if store offset plus store size is greater than the load offset.
- R4: For equal bases, when the store offset is above the load offset, the load hits if and only if load offset plus load size is greater than the store offset.
- R5: A load whose base differs from the base of every recorded store never hits.
- R6: With ld_valid_i low, hit_o is 0 whatever the other load inputs are.
- R7: At most N_SLOTS (default 4) stores are recorded per group, in commit order. Commits after the slots are full are ignored.
- R8: A grp_end_i pulse clears every record from the next cycle on.
- R9: When st_commit_i and grp_end_i are high in the same cycle, the clear wins and the store is not recorded.
- R10: A committed store affects hit_o from the cycle after its commit edge, not during its own commit cycle.
- R11: Offsets are 32-bit two's complement and sizes are 8-bit unsigned. The overlap sums never wrap, so a store at offset 0x7FFFFFFF of size 255 does not overlap a load at offset 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_commit_i | input | 1 | Store commit strobe |
| st_base_i | input | 16 | Base identifier of the committed store |
| st_ofs_i | input | 32 | Signed offset of the committed store |
| st_size_i | input | 8 | Byte count of the committed store |
| grp_end_i | input | 1 | Dispatch group end; clears all records |
| ld_valid_i | input | 1 | Load candidate present |
| ld_base_i | input | 16 | Base identifier of the load |
| ld_ofs_i | input | 32 | Signed offset of the load |
| ld_size_i | input | 8 | Byte count of the load |
| hit_o | output | 1 | Load overlaps a recorded store |

## Verification
A wrong fill count or a missed clear shows up at hit_o as a stale or missing hit. It appears on the first load probed after the faulty commit or group-end edge, because the output depends combinationally on the registered records. Interval errors in the compare show up as a wrong hit_o at once, at the exact offset and size boundaries. The bench therefore sweeps every combination of store and load offsets and sizes in a small window. It also probes the signed extremes, where a truncated sum would wrap.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int BASE_W = 16;
  localparam int OFS_W  = 32;
  localparam int SIZE_W = 8;
  localparam int CMP_W  = OFS_W + 2;

  typedef struct packed {
    logic [BASE_W-1:0]        base;
    logic signed [OFS_W-1:0]  ofs;
    logic [SIZE_W-1:0]        size;
  } acc_t;
endpackage

// File: rtl/sld_fill_ctrl.sv
module sld_fill_ctrl #(
  parameter int N_SLOTS = 4,
  localparam int CNT_W = $clog2(N_SLOTS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic               clear_i,
  output logic [N_SLOTS-1:0] wr_en_o,
  output logic [N_SLOTS-1:0] valid_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;

  assign full = (cnt_q == CNT_W'(N_SLOTS));

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)              cnt_d = '0;
    else if (commit_i && !full) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot_ctl
    assign wr_en_o[i] = commit_i && !clear_i && (cnt_q == CNT_W'(i));
    assign valid_o[i] = (cnt_q > CNT_W'(i));
  end

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (valid_o == '0));
  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && commit_i) |=> (cnt_q == '0));
  assert_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_SLOTS));
  assert_full_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !clear_i) |=> full);
  assert_one_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  assert_grow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !clear_i && !full) |=> ($countones(valid_o) == $countones($past(valid_o)) + 1));
endmodule

// File: rtl/sld_slot.sv
module sld_slot
  import sld_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  acc_t wr_acc_i,
  input  logic valid_i,
  input  acc_t ld_acc_i,
  output logic hit_o
);
  acc_t st_q;
  logic signed [CMP_W-1:0] st_lo, st_hi, ld_lo, ld_hi;
  logic                    ovl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= '0;
    else if (wr_en_i) st_q <= wr_acc_i;
  end

  // widen before adding so the end address cannot wrap
  assign st_lo = CMP_W'(st_q.ofs);
  assign ld_lo = CMP_W'(ld_acc_i.ofs);
  assign st_hi = st_lo + $signed({{(CMP_W-SIZE_W){1'b0}}, st_q.size});
  assign ld_hi = ld_lo + $signed({{(CMP_W-SIZE_W){1'b0}}, ld_acc_i.size});

  always_comb begin
    if (st_lo == ld_lo)     ovl = 1'b1;
    else if (st_lo < ld_lo) ovl = (st_hi > ld_lo);
    else                    ovl = (ld_hi > st_lo);
  end

  assign hit_o = valid_i && (st_q.base == ld_acc_i.base) && ovl;

  assert_slot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(st_q));
  assert_base_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q.base != ld_acc_i.base) |-> !hit_o);
endmodule

// File: rtl/store_load_overlap.sv
module store_load_overlap
  import sld_pkg::*;
#(
  parameter int N_SLOTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_commit_i,
  input  logic [15:0]       st_base_i,
  input  logic [31:0]       st_ofs_i,
  input  logic [7:0]        st_size_i,
  input  logic              grp_end_i,
  input  logic              ld_valid_i,
  input  logic [15:0]       ld_base_i,
  input  logic [31:0]       ld_ofs_i,
  input  logic [7:0]        ld_size_i,
  output logic              hit_o
);
  logic [N_SLOTS-1:0] wr_en, valid, slot_hit;
  acc_t               st_acc, ld_acc;

  assign st_acc = '{base: st_base_i, ofs: st_ofs_i, size: st_size_i};
  assign ld_acc = '{base: ld_base_i, ofs: ld_ofs_i, size: ld_size_i};

  sld_fill_ctrl #(.N_SLOTS(N_SLOTS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (st_commit_i),
    .clear_i  (grp_end_i),
    .wr_en_o  (wr_en),
    .valid_o  (valid)
  );

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    sld_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en[i]),
      .wr_acc_i (st_acc),
      .valid_i  (valid[i]),
      .ld_acc_i (ld_acc),
      .hit_o    (slot_hit[i])
    );
  end

  assign hit_o = ld_valid_i && (|slot_hit);

  assert_ld_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |-> !hit_o);
  assert_empty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid == '0) |-> !hit_o);
  assert_post_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_end_i |=> !hit_o);
endmodule

// File: tb/store_load_overlap_tb.sv
module store_load_overlap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_commit = 1'b0, grp_end = 1'b0, ld_valid = 1'b0;
  logic [15:0] st_base = '0, ld_base = '0;
  logic [31:0] st_ofs = '0, ld_ofs = '0;
  logic [7:0]  st_size = '0, ld_size = '0;
  logic        hit;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  store_load_overlap dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .st_commit_i(st_commit), .st_base_i(st_base), .st_ofs_i(st_ofs), .st_size_i(st_size),
    .grp_end_i(grp_end),
    .ld_valid_i(ld_valid), .ld_base_i(ld_base), .ld_ofs_i(ld_ofs), .ld_size_i(ld_size),
    .hit_o(hit)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
    end
  end

  function automatic bit model(int sb, longint so, int ss, int lb, longint lo, int ls);
    if (sb != lb) return 1'b0;
    if (so == lo) return 1'b1;
    if (so < lo)  return (so + ss) > lo;
    return (lo + ls) > so;
  endfunction

  task automatic check(bit exp, string req);
    n_chk++;
    if (hit !== exp) begin
      n_fail++;
      $display("FAIL %s: hit actual=%b expected=%b", req, hit, exp);
    end
  endtask

  task automatic commit(int b, logic [31:0] o, int s, bit endg);
    @(negedge clk);
    st_commit = 1'b1; st_base = 16'(b); st_ofs = o; st_size = 8'(s); grp_end = endg;
    @(negedge clk);
    st_commit = 1'b0; grp_end = 1'b0;
  endtask

  task automatic end_group();
    @(negedge clk); grp_end = 1'b1;
    @(negedge clk); grp_end = 1'b0;
  endtask

  task automatic probe(int b, logic [31:0] o, int s, bit v, bit exp, string req);
    ld_base = 16'(b); ld_ofs = o; ld_size = 8'(s); ld_valid = v;
    #0.5;
    check(exp, req);
    ld_valid = 1'b0;
  endtask

  initial begin
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset
    probe(0, 0, 4, 1'b1, 1'b0, "R1");
    probe(7, -1, 255, 1'b1, 1'b0, "R1");

    // R2 R3 R4 R5: single-store sweep
    for (int sb = 0; sb < 2; sb++)
      for (int so = -4; so <= 4; so++)
        for (int ss = 0; ss < 4; ss++) begin
          end_group();
          commit(sb, 32'(so), ss, 1'b0);
          for (int lo = -4; lo <= 4; lo++)
            for (int ls = 0; ls < 4; ls++) begin
              string r;
              if (sb != 0)      r = "R5";
              else if (so == lo) r = "R2";
              else if (so < lo) r = "R3";
              else               r = "R4";
              probe(0, 32'(lo), ls, 1'b1, model(sb, so, ss, 0, lo, ls), r);
            end
        end

    // R6: valid low masks a certain hit
    end_group();
    commit(5, 32'd100, 4, 1'b0);
    probe(5, 32'd100, 4, 1'b0, 1'b0, "R6");
    probe(5, 32'd100, 4, 1'b1, 1'b1, "R6");

    // R7: fifth store ignored
    end_group();
    for (int k = 0; k < 5; k++) commit(2, 32'(k * 10), 1, 1'b0);
    for (int k = 0; k < 5; k++) probe(2, 32'(k * 10), 1, 1'b1, k < 4, "R7");

    // R8: group end clears all
    end_group();
    for (int k = 0; k < 4; k++) probe(2, 32'(k * 10), 1, 1'b1, 1'b0, "R8");

    // R9: clear beats a same-cycle commit
    commit(3, 32'd50, 2, 1'b0);
    commit(3, 32'd60, 2, 1'b1);
    probe(3, 32'd60, 2, 1'b1, 1'b0, "R9");
    probe(3, 32'd50, 2, 1'b1, 1'b0, "R9");
    commit(3, 32'd70, 2, 1'b0);
    probe(3, 32'd70, 2, 1'b1, 1'b1, "R9");

    // R10: not visible during its own commit cycle
    end_group();
    @(negedge clk);
    st_commit = 1'b1; st_base = 16'd9; st_ofs = 32'd8; st_size = 8'd4;
    probe(9, 32'd8, 4, 1'b1, 1'b0, "R10");
    @(negedge clk);
    st_commit = 1'b0;
    probe(9, 32'd8, 4, 1'b1, 1'b1, "R10");

    // R11: signed extremes do not wrap
    end_group();
    commit(4, 32'h7FFF_FFFF, 255, 1'b0);
    probe(4, 32'h8000_0000, 255, 1'b1, 1'b0, "R11");
    probe(4, 32'h7FFF_FFFE, 1, 1'b1, 1'b0, "R11");
    probe(4, 32'h7FFF_FFFE, 2, 1'b1, 1'b1, "R11");
    end_group();
    commit(4, 32'h8000_0000, 255, 1'b0);
    probe(4, 32'h7FFF_FFFF, 255, 1'b1, 1'b0, "R11");
    probe(4, 32'h8000_00FE, 1, 1'b1, 1'b1, "R11");
    probe(4, 32'h8000_00FF, 1, 1'b1, 1'b0, "R11");

    summary();
  end
endmodule